// File: doc/BRIEF.md
# Two-Word Burst Double-Rate SRAM Model

This block is a synthesizable model of a small synchronous SRAM. Address and control run at single rate, and every request moves a two-word burst. The double-rate data port is shown as two single-rate buses in one clock domain: one bus carries the rising-phase word and the other the falling-phase word.

At most one request is accepted on each rising clock edge. A write stores both words of its burst as one wide row. Each 9-bit lane of each word has its own active-low enable. The lowest address bit picks which stored word leaves first, so a burst wraps inside its row. A read issued right after a write to the same row returns the new contents through a forwarding path. The read outputs carry an enable flag that is high only while valid read data is present. A free-running echo clock is also brought out.

The data path has no back-pressure. A request is never stalled. Write data must be present at the edge after its request, and read data must be taken during the cycle in which the output enable is high. The port set is plain by design: a valid/ready handshake would add a cycle of storage that the device timing does not allow.

Top module: `burst2_sram`

## Requirements
- R1: When `load_n` is high at a rising edge, no request starts and `rd_wr` is ignored. No output window follows, and the row keeps its contents even if data is presented at the next edge.
- R2: A read request is `load_n`=0 with `rd_wr`=1. With `READ_STAGES`=1, `rd_oe` is high and both read words are valid for exactly the one cycle that starts at the first rising edge after the request edge.
- R3: A write request is `load_n`=0 with `rd_wr`=0. The address is taken at the request edge. Both phase words and both sets of byte enables are taken at the next rising edge.
- R4: Byte enables are active low. Bit l of `be_rise_n` or `be_fall_n` covers data bits 9l+8 down to 9l of the matching word. A lane whose enable is high keeps its stored value.
- R5: `addr[0]` is the burst start bit and `addr[ADDR_W-1:1]` selects the row. A write with start bit s puts the rising word in slot s and the falling word in slot 1-s. A read with start bit s returns slot s on `rd_rise` and slot 1-s on `rd_fall`. Order 0,1 or 1,0 wraps inside the row.
- R6: A read accepted on the edge right after a write to the same row returns the merged new contents, including partly masked lanes.
- R7: A write request on the edge right after an accepted read is dropped as a no-operation, and the row is left unchanged.
- R8: When no read window is active, `rd_oe` is 0 and both read buses are zero. This holds during reset and right after it.
- R9: `echo_clk` toggles with every clock cycle at all times, including during reset and while `rd_oe` is low.
- R10: Requests may be issued on every edge back to back in any mix. Each accepted read returns the contents produced by all earlier accepted writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all requests are taken on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_n | input | 1 | Active-low request strobe |
| rd_wr | input | 1 | 1 = read, 0 = write, used only when `load_n` is 0 |
| addr | input | ADDR_W | Row in the upper bits, burst start word in bit 0 |
| wr_rise | input | 9*LANES | First (rising-phase) write word |
| wr_fall | input | 9*LANES | Second (falling-phase) write word |
| be_rise_n | input | LANES | Active-low lane enables for `wr_rise` |
| be_fall_n | input | LANES | Active-low lane enables for `wr_fall` |
| rd_rise | output | 9*LANES | First (rising-phase) read word |
| rd_fall | output | 9*LANES | Second (falling-phase) read word |
| rd_oe | output | 1 | High while the read buses carry valid data |
| echo_clk | output | 1 | Free-running echo of the clock |

## Verification
The hardest case to reach from the ports is a forwarded read whose write had some lanes masked. The row must already hold known data. The write must then be followed on the very next edge by a read of the same row, while that same edge carries the write's data buses. The bench first fills a set of rows. It then issues write and read as consecutive slots with mixed enables and both start-bit values, and finally runs a long random back-to-back sequence over only eight rows. That sequence also produces writes that come right after reads, and the scoreboard has to drop those writes.

// File: rtl/burst2_pkg.sv
package burst2_pkg;
  localparam int LANE_W = 9;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/burst2_cmd.sv
module burst2_cmd
  import burst2_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_n,
  input  logic              rd_wr,
  input  logic [ADDR_W-1:0] addr,
  output logic              acc_rd,
  output op_e               op_q,
  output logic [ADDR_W-2:0] row_q,
  output logic              sa0_q
);
  logic acc_wr;
  logic last_rd;

  assign last_rd = (op_q == OP_READ);
  assign acc_rd  = !load_n && rd_wr;
  assign acc_wr  = !load_n && !rd_wr && !last_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q  <= OP_IDLE;
      row_q <= '0;
      sa0_q <= 1'b0;
    end else begin
      if (acc_rd)      op_q <= OP_READ;
      else if (acc_wr) op_q <= OP_WRITE;
      else             op_q <= OP_IDLE;
      if (acc_rd || acc_wr) begin
        row_q <= addr[ADDR_W-1:1];
        sa0_q <= addr[0];
      end
    end
  end

  // R1: a high strobe starts nothing
  p_idle_on_load_high_r1: assert property (@(posedge clk) disable iff (rst)
    load_n |=> (op_q == OP_IDLE));

  // R7: a write slot right after a read is dropped
  p_no_wr_after_rd_r7: assert property (@(posedge clk) disable iff (rst)
    (op_q == OP_READ && !load_n && !rd_wr) |=> (op_q == OP_IDLE));

  // R3: a pending write always comes from a write request one edge earlier
  p_wr_needs_req_r3: assert property (@(posedge clk) disable iff (rst)
    (op_q == OP_WRITE) |-> $past(!load_n && !rd_wr));
endmodule

// File: rtl/burst2_array.sv
module burst2_array
  import burst2_pkg::*;
#(
  parameter int ROW_W = 7,
  parameter int LANES = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ROW_W-1:0]           wr_row,
  input  logic                       wr_sa0,
  input  logic [LANES*LANE_W-1:0]    wr_rise,
  input  logic [LANES*LANE_W-1:0]    wr_fall,
  input  logic [LANES-1:0]           be_rise_n,
  input  logic [LANES-1:0]           be_fall_n,
  input  logic                       rd_en,
  input  logic [ROW_W-1:0]           rd_row,
  output logic [2*LANES*LANE_W-1:0]  rd_entry_q,
  output logic [2*LANES*LANE_W-1:0]  fwd_entry_q,
  output logic [2*LANES-1:0]         fwd_mask_q,
  output logic                       fwd_hit_q
);
  localparam int W    = LANES * LANE_W;
  localparam int E    = 2 * W;
  localparam int ML   = 2 * LANES;
  localparam int ROWS = 1 << ROW_W;

  logic [E-1:0]  mem [ROWS];
  logic [E-1:0]  new_entry;
  logic [E-1:0]  old_entry;
  logic [E-1:0]  merged;
  logic [ML-1:0] new_mask;

  // slot 0 in the low half, slot 1 in the high half
  always_comb begin
    if (wr_sa0) begin
      new_entry = {wr_rise, wr_fall};
      new_mask  = {~be_rise_n, ~be_fall_n};
    end else begin
      new_entry = {wr_fall, wr_rise};
      new_mask  = {~be_fall_n, ~be_rise_n};
    end
  end

  assign old_entry = mem[wr_row];

  for (genvar l = 0; l < ML; l++) begin : g_lane
    assign merged[l*LANE_W +: LANE_W] =
      new_mask[l] ? new_entry[l*LANE_W +: LANE_W] : old_entry[l*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_row] <= merged;
    if (rd_en) rd_entry_q <= mem[rd_row];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_hit_q   <= 1'b0;
      fwd_mask_q  <= '0;
      fwd_entry_q <= '0;
    end else begin
      fwd_hit_q   <= rd_en && wr_en && (rd_row == wr_row);
      fwd_mask_q  <= new_mask;
      fwd_entry_q <= new_entry;
    end
  end
endmodule

// File: rtl/burst2_rdout.sv
module burst2_rdout
  import burst2_pkg::*;
#(
  parameter int LANES       = 2,
  parameter int READ_STAGES = 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rd_vld_in,
  input  logic                      sa0_in,
  input  logic [2*LANES*LANE_W-1:0] rd_entry,
  input  logic [2*LANES*LANE_W-1:0] fwd_entry,
  input  logic [2*LANES-1:0]        fwd_mask,
  input  logic                      fwd_hit,
  output logic [LANES*LANE_W-1:0]   rd_rise,
  output logic [LANES*LANE_W-1:0]   rd_fall,
  output logic                      rd_oe
);
  localparam int W  = LANES * LANE_W;
  localparam int ML = 2 * LANES;

  logic [2*W-1:0] entry_c;
  logic [W-1:0]   rise_c;
  logic [W-1:0]   fall_c;

  for (genvar l = 0; l < ML; l++) begin : g_fwd
    assign entry_c[l*LANE_W +: LANE_W] = (fwd_hit && fwd_mask[l]) ?
      fwd_entry[l*LANE_W +: LANE_W] : rd_entry[l*LANE_W +: LANE_W];
  end

  assign rise_c = sa0_in ? entry_c[2*W-1:W] : entry_c[W-1:0];
  assign fall_c = sa0_in ? entry_c[W-1:0]   : entry_c[2*W-1:W];

  logic [READ_STAGES-1:0]        vld_s;
  logic [READ_STAGES-1:0][W-1:0] r_s;
  logic [READ_STAGES-1:0][W-1:0] f_s;

  for (genvar s = 0; s < READ_STAGES; s++) begin : g_stage
    logic          v_in;
    logic [W-1:0]  r_in;
    logic [W-1:0]  f_in;
    if (s == 0) begin : g_first
      assign v_in = rd_vld_in;
      assign r_in = rise_c;
      assign f_in = fall_c;
    end else begin : g_next
      assign v_in = vld_s[s-1];
      assign r_in = r_s[s-1];
      assign f_in = f_s[s-1];
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        vld_s[s] <= 1'b0;
        r_s[s]   <= '0;
        f_s[s]   <= '0;
      end else begin
        vld_s[s] <= v_in;
        r_s[s]   <= v_in ? r_in : '0;
        f_s[s]   <= v_in ? f_in : '0;
      end
    end
  end

  assign rd_oe   = vld_s[READ_STAGES-1];
  assign rd_rise = r_s[READ_STAGES-1];
  assign rd_fall = f_s[READ_STAGES-1];

  // R8: outputs come out of reset disabled
  p_oe_off_after_reset_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rd_oe && rd_rise == '0 && rd_fall == '0));

  // R8: a stage that is not valid never carries data
  p_quiet_when_off_r8: assert property (@(posedge clk) disable iff (rst)
    !rd_oe |-> (rd_rise == '0 && rd_fall == '0));
endmodule

// File: rtl/burst2_sram.sv
module burst2_sram
  import burst2_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int LANES       = 2,
  parameter int READ_STAGES = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load_n,
  input  logic                    rd_wr,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wr_rise,
  input  logic [LANES*LANE_W-1:0] wr_fall,
  input  logic [LANES-1:0]        be_rise_n,
  input  logic [LANES-1:0]        be_fall_n,
  output logic [LANES*LANE_W-1:0] rd_rise,
  output logic [LANES*LANE_W-1:0] rd_fall,
  output logic                    rd_oe,
  output logic                    echo_clk
);
  localparam int ROW_W = ADDR_W - 1;
  localparam int W     = LANES * LANE_W;

  logic              acc_rd;
  op_e               op_q;
  logic [ROW_W-1:0]  row_q;
  logic              sa0_q;
  logic [2*W-1:0]    rd_entry_q;
  logic [2*W-1:0]    fwd_entry_q;
  logic [2*LANES-1:0] fwd_mask_q;
  logic              fwd_hit_q;

  burst2_cmd #(.ADDR_W(ADDR_W)) u_cmd (
    .clk(clk), .rst(rst), .load_n(load_n), .rd_wr(rd_wr), .addr(addr),
    .acc_rd(acc_rd), .op_q(op_q), .row_q(row_q), .sa0_q(sa0_q)
  );

  burst2_array #(.ROW_W(ROW_W), .LANES(LANES)) u_array (
    .clk(clk), .rst(rst),
    .wr_en(op_q == OP_WRITE), .wr_row(row_q), .wr_sa0(sa0_q),
    .wr_rise(wr_rise), .wr_fall(wr_fall),
    .be_rise_n(be_rise_n), .be_fall_n(be_fall_n),
    .rd_en(acc_rd), .rd_row(addr[ADDR_W-1:1]),
    .rd_entry_q(rd_entry_q), .fwd_entry_q(fwd_entry_q),
    .fwd_mask_q(fwd_mask_q), .fwd_hit_q(fwd_hit_q)
  );

  burst2_rdout #(.LANES(LANES), .READ_STAGES(READ_STAGES)) u_rdout (
    .clk(clk), .rst(rst),
    .rd_vld_in(op_q == OP_READ), .sa0_in(sa0_q),
    .rd_entry(rd_entry_q), .fwd_entry(fwd_entry_q),
    .fwd_mask(fwd_mask_q), .fwd_hit(fwd_hit_q),
    .rd_rise(rd_rise), .rd_fall(rd_fall), .rd_oe(rd_oe)
  );

  // R9: the echo runs straight from the clock, independent of reset and reads
  assign echo_clk = clk;
endmodule

// File: tb/burst2_sram_bench.sv
module burst2_sram_bench;
  localparam int AW   = 8;
  localparam int L    = 2;
  localparam int W    = L * 9;
  localparam int ROWS = 1 << (AW - 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load_n = 1'b1;
  logic          rd_wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [W-1:0]  wr_rise = '0, wr_fall = '0;
  logic [L-1:0]  be_rise_n = '1, be_fall_n = '1;
  logic [W-1:0]  rd_rise, rd_fall;
  logic          rd_oe, echo_clk;

  always #5 clk = ~clk;

  burst2_sram #(.ADDR_W(AW), .LANES(L), .READ_STAGES(1)) u_burst2_sram (
    .clk(clk), .rst(rst), .load_n(load_n), .rd_wr(rd_wr), .addr(addr),
    .wr_rise(wr_rise), .wr_fall(wr_fall), .be_rise_n(be_rise_n), .be_fall_n(be_fall_n),
    .rd_rise(rd_rise), .rd_fall(rd_fall), .rd_oe(rd_oe), .echo_clk(echo_clk)
  );

  int n_checks = 0, n_errors = 0, echo_cnt = 0;
  bit done = 0;
  always @(posedge echo_clk) echo_cnt++;

  // scoreboard
  logic [W-1:0] m0 [ROWS];
  logic [W-1:0] m1 [ROWS];
  bit pw_vld = 0, pw_sa0 = 0, last_rd_m = 0;
  logic [AW-2:0] pw_row = '0;
  bit ea_vld = 0, eb_vld = 0;
  logic [W-1:0] ea_r = '0, ea_f = '0, eb_r = '0, eb_f = '0;
  string ea_tag = "R8", eb_tag = "R8";

  function automatic logic [W-1:0] lanes(input logic [W-1:0] o, input logic [W-1:0] n,
                                         input logic [L-1:0] ben);
    for (int l = 0; l < L; l++) if (!ben[l]) o[l*9 +: 9] = n[l*9 +: 9];
    return o;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one clock slot: check outputs of the edge just passed, then drive the next slot.
  // dr/df/br/bf are the data buses for a write requested in the previous slot.
  task automatic tick(input bit ld, input bit rw, input logic [AW-1:0] a,
                      input logic [W-1:0] dr, input logic [W-1:0] df,
                      input logic [L-1:0] br, input logic [L-1:0] bf, input string tag);
    logic [AW-2:0] row;
    bit ar, aw;
    @(negedge clk);
    check(rd_oe === ea_vld, ea_tag, "rd_oe", {{(W-1){1'b0}}, rd_oe}, {{(W-1){1'b0}}, ea_vld});
    if (ea_vld) begin
      check(rd_rise === ea_r, ea_tag, "rd_rise", rd_rise, ea_r);
      check(rd_fall === ea_f, ea_tag, "rd_fall", rd_fall, ea_f);
    end else begin
      check(rd_rise === '0 && rd_fall === '0, "R8", "idle data", rd_rise | rd_fall, '0);
    end
    ea_vld = eb_vld; ea_r = eb_r; ea_f = eb_f; ea_tag = eb_tag;
    if (pw_vld) begin
      if (pw_sa0) begin
        m1[pw_row] = lanes(m1[pw_row], dr, br);
        m0[pw_row] = lanes(m0[pw_row], df, bf);
      end else begin
        m0[pw_row] = lanes(m0[pw_row], dr, br);
        m1[pw_row] = lanes(m1[pw_row], df, bf);
      end
    end
    load_n = ld; rd_wr = rw; addr = a;
    wr_rise = dr; wr_fall = df; be_rise_n = br; be_fall_n = bf;
    ar = !ld && rw;
    aw = !ld && !rw && !last_rd_m;
    row = a[AW-1:1];
    eb_vld = ar; eb_tag = tag;
    eb_r = a[0] ? m1[row] : m0[row];
    eb_f = a[0] ? m0[row] : m1[row];
    pw_vld = aw; pw_row = row; pw_sa0 = a[0];
    last_rd_m = ar;
  endtask

  task automatic idle(input logic [W-1:0] dr = '0, input logic [W-1:0] df = '0,
                      input logic [L-1:0] br = '1, input logic [L-1:0] bf = '1);
    tick(1, 0, '0, dr, df, br, bf, "R8");
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    tick(0, 1, a, '0, '0, '1, '1, tag);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d0, input logic [W-1:0] d1,
                    input logic [L-1:0] br, input logic [L-1:0] bf);
    tick(0, 0, a, '0, '0, '1, '1, "R3");
    idle(d0, d1, br, bf);
  endtask

  task automatic flush();
    repeat (3) idle();
  endtask

  task automatic t_reset();
    int c0;
    c0 = echo_cnt;
    repeat (5) begin
      @(negedge clk);
      check(!rd_oe && rd_rise === '0 && rd_fall === '0, "R8", "reset outputs",
            rd_rise | rd_fall | {{(W-1){1'b0}}, rd_oe}, '0);
    end
    check(echo_cnt - c0 == 5, "R9", "echo edges in reset", W'(echo_cnt - c0), W'(5));
    rst = 1'b0;
  endtask

  task automatic t_fill();
    for (int r = 0; r < 16; r++)
      wr({r[AW-2:0], 1'b0}, W'(18'h10000 + r * 3), W'(18'h20000 + r * 5), '0, '0);
    for (int r = 0; r < 16; r += 5) begin
      rd({r[AW-2:0], 1'b0}, "R2");
      idle();
    end
    flush();
  endtask

  task automatic t_lanes();
    wr({7'd3, 1'b0}, 18'h3ffff, 18'h2aaaa, 2'b10, 2'b01);
    rd({7'd3, 1'b0}, "R4");
    flush();
    wr({7'd4, 1'b0}, 18'h15555, 18'h0f0f0, 2'b11, 2'b11);
    rd({7'd4, 1'b0}, "R4");
    flush();
  endtask

  task automatic t_wrap();
    wr({7'd5, 1'b1}, 18'h0aaaa, 18'h05555, '0, '0);
    rd({7'd5, 1'b0}, "R5");
    idle();
    rd({7'd5, 1'b1}, "R5");
    flush();
  endtask

  task automatic t_forward();
    tick(0, 0, {7'd6, 1'b0}, '0, '0, '1, '1, "R6");
    tick(0, 1, {7'd6, 1'b0}, 18'h12345, 18'h0beef, '0, '0, "R6");
    flush();
    tick(0, 0, {7'd7, 1'b1}, '0, '0, '1, '1, "R6");
    tick(0, 1, {7'd7, 1'b0}, 18'h3c3c3, 18'h01ff1, 2'b01, 2'b10, "R6");
    flush();
  endtask

  task automatic t_rd_then_wr();
    rd({7'd2, 1'b0}, "R7");
    tick(0, 0, {7'd2, 1'b0}, '0, '0, '1, '1, "R7");
    idle(18'h3ffff, 18'h3ffff, '0, '0);
    rd({7'd2, 1'b0}, "R7");
    flush();
  endtask

  task automatic t_load_high();
    tick(1, 0, {7'd8, 1'b0}, '0, '0, '1, '1, "R1");
    idle(18'h00001, 18'h00002, '0, '0);
    tick(1, 1, {7'd8, 1'b0}, '0, '0, '1, '1, "R1");
    idle();
    rd({7'd8, 1'b0}, "R1");
    flush();
  endtask

  task automatic t_b2b();
    for (int r = 0; r < 4; r++) rd({r[AW-2:0], r[0]}, "R10");
    flush();
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [AW-1:0] a;
      op = int'($urandom % 4);
      a  = {4'd0, 3'($urandom), 1'($urandom)};
      tick(op == 0, op != 2, a, W'($urandom), W'($urandom), L'($urandom), L'($urandom), "R10");
    end
    flush();
  endtask

  task automatic t_echo();
    int c0;
    c0 = echo_cnt;
    repeat (20) @(negedge clk);
    check(echo_cnt - c0 == 20, "R9", "echo edges idle", W'(echo_cnt - c0), W'(20));
  endtask

  initial begin
    for (int r = 0; r < ROWS; r++) begin m0[r] = '0; m1[r] = '0; end
    t_reset();
    t_fill();
    t_lanes();
    t_wrap();
    t_forward();
    t_rd_then_wr();
    t_load_high();
    t_b2b();
    t_echo();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule